// File: doc/BRIEF.md
# Command/Status Front End for a Slow Peripheral

This block sits between a processor's register bus and a peripheral that takes an unknown number of cycles to carry out an operation. Software loads operands into a small bank of data registers, then writes an opcode into the command register. The controller forwards the opcode and operands to the peripheral with a one-cycle start pulse and reports progress through a status register.

Progress is tracked by two status flags, busy and done, which together act as a three-state machine: idle (both clear), working (busy only) and finished (done only). The combination with both flags set is never produced. When the peripheral signals completion with an outcome code, busy falls, done rises and a completion interrupt flag is raised. Software acknowledges by clearing done, which returns the controller to idle and drops the interrupt. Commands issued at the wrong time are refused and leave a sticky refusal code behind.

Top module: `devctl_top`

## Requirements
- R1: After reset the status register reads 0 (idle, outcome code 0), the interrupt flag is low and every data register reads 0.
- R2: The status register is read at address 1 with done at bit 0, busy at bit 1, bits 3:2 zero and the 4-bit outcome code at bits 7:4; the command register is at address 0 and data register i at address 2+i.
- R3: A command write in the idle state is accepted: on the next cycle busy reads 1, `dev_start` is high for exactly that one cycle, `dev_cmd` holds the written value and the outcome code reads 0.
- R4: A `dev_done` pulse while busy makes the controller finished on the next cycle: busy 0, done 1, interrupt flag 1, outcome code taken from `dev_err`.
- R5: A command write while busy or done has no effect on state, command or `dev_start`, and sets the outcome code to 4'hF; this refusal code survives a later completion and remains until the next accepted command.
- R6: Data register writes are ignored while busy and take effect when idle or finished; the data registers drive `dev_data`.
- R7: Writing the status register with bit 0 equal to 0 while finished returns the controller to idle and clears the interrupt flag; a status write with bit 0 equal to 1 changes nothing.
- R8: A done-clearing status write in the same cycle as a completion leaves the controller finished with the interrupt flag set.
- R9: A `dev_done` pulse while not busy is ignored.
- R10: Busy and done are never read as 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (read and write) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_pend | output | 1 | Completion interrupt pending |
| dev_start | output | 1 | One-cycle start pulse to the peripheral |
| dev_cmd | output | DATA_W | Accepted command value |
| dev_data | output | N_DATA*DATA_W | Data register bank, register i in slice i |
| dev_done | input | 1 | Completion pulse from the peripheral |
| dev_err | input | 4 | Outcome code, valid with `dev_done` |

## Verification
The command path is exercised from idle, from working and from finished, so accepted and refused commands are told apart by the start pulse and the outcome code. Completions are driven with different outcome codes, after a refusal and without one, which separates a sticky refusal from a plain device code. Data writes are tried while idle, while working and while finished, and the acknowledge is tried with both values of bit 0, alone and in the same cycle as a completion.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_DONE = 2'b01,
        ST_BUSY = 2'b10
    } st_e;

    localparam int ADDR_CMD   = 0;
    localparam int ADDR_STAT  = 1;
    localparam int DATA_BASE  = 2;
    localparam logic [3:0] ERR_REFUSED = 4'hF;

    function automatic logic [7:0] pack_status(st_e s, logic [3:0] code);
        return {code, 2'b00, s};
    endfunction

endpackage

// File: rtl/devctl_status.sv
module devctl_status
    import devctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic       ack_wr,
    input  logic       dev_done,
    input  logic [3:0] dev_err,
    output st_e        state,
    output logic [3:0] code,
    output logic       irq,
    output logic       accept
);
    assign accept = cmd_wr && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            irq   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) state <= ST_BUSY;
                ST_BUSY: if (dev_done) begin
                    state <= ST_DONE;
                    irq   <= 1'b1;
                end
                ST_DONE: if (ack_wr) begin
                    state <= ST_IDLE;
                    irq   <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= 4'h0;
        end else if (accept) begin
            code <= 4'h0;
        end else if (cmd_wr) begin
            code <= ERR_REFUSED;
        end else if (state == ST_BUSY && dev_done && code != ERR_REFUSED) begin
            code <= dev_err;
        end
    end
endmodule

// File: rtl/devctl_regs.sv
module devctl_regs
    import devctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int N_DATA = 4,
    parameter int ADDR_W = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       accept,
    input  logic                       busy,
    output logic [DATA_W-1:0]          cmd_q,
    output logic                       start_q,
    output logic [N_DATA*DATA_W-1:0]   data_flat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= accept;
            if (accept) cmd_q <= wdata;
        end
    end

    for (genvar i = 0; i < N_DATA; i++) begin : g_data
        logic [DATA_W-1:0] reg_q;
        logic              hit;
        assign hit = wr && !busy && (addr == ADDR_W'(DATA_BASE + i));
        always_ff @(posedge clk) begin
            if (rst)      reg_q <= '0;
            else if (hit) reg_q <= wdata;
        end
        assign data_flat[i*DATA_W +: DATA_W] = reg_q;
    end
endmodule

// File: rtl/devctl_top.sv
module devctl_top
    import devctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int N_DATA = 4,
    parameter int ADDR_W = $clog2(N_DATA + 2)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     irq_pend,
    output logic                     dev_start,
    output logic [DATA_W-1:0]        dev_cmd,
    output logic [N_DATA*DATA_W-1:0] dev_data,
    input  logic                     dev_done,
    input  logic [3:0]               dev_err
);
    localparam int N_REGS = N_DATA + DATA_BASE;

    st_e        state;
    logic [3:0] code;
    logic       accept;
    logic       busy;
    logic       done;
    logic       cmd_wr;
    logic       ack_wr;

    assign cmd_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_CMD));
    assign ack_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_STAT)) && !bus_wdata[0];
    assign busy   = state[1];
    assign done   = state[0];

    devctl_status u_status (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .ack_wr   (ack_wr),
        .dev_done (dev_done),
        .dev_err  (dev_err),
        .state    (state),
        .code     (code),
        .irq      (irq_pend),
        .accept   (accept)
    );

    devctl_regs #(
        .DATA_W (DATA_W),
        .N_DATA (N_DATA),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .accept    (accept),
        .busy      (busy),
        .cmd_q     (dev_cmd),
        .start_q   (dev_start),
        .data_flat (dev_data)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_CMD)) begin
            bus_rdata = dev_cmd;
        end else if (bus_addr == ADDR_W'(ADDR_STAT)) begin
            bus_rdata = DATA_W'(pack_status(state, code));
        end else begin
            for (int i = 0; i < N_DATA; i++) begin
                if (bus_addr == ADDR_W'(DATA_BASE + i))
                    bus_rdata = dev_data[i*DATA_W +: DATA_W];
            end
        end
    end

    initial begin
        if (N_REGS > (1 << ADDR_W)) $display("devctl_top: ADDR_W too small");
    end
endmodule

// File: rtl/devctl_chk.sv
module devctl_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic irq_pend,
    input logic dev_start,
    input logic dev_done
);
    AST_NO_BOTH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R10
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dev_start |=> !dev_start); // R3
    AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
        dev_start |-> busy); // R3
    AST_COMPLETE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (busy && dev_done) |=> (done && irq_pend && !busy)); // R4
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !dev_done) |=> busy); // R5
    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        irq_pend |-> done); // R7
    AST_IDLE_IGNORES_DONE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |=> !done); // R9
endmodule

bind devctl_top devctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .irq_pend  (irq_pend),
    .dev_start (dev_start),
    .dev_done  (dev_done)
);

// File: tb/devctl_top_tb_top.sv
module devctl_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int ND = 4;
    localparam int AW = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_wr = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic           irq_pend;
    logic           dev_start;
    logic [DW-1:0]  dev_cmd;
    logic [ND*DW-1:0] dev_data;
    logic           dev_done = 1'b0;
    logic [3:0]     dev_err = 4'h0;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    event          rd_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    devctl_top #(.DATA_W(DW), .N_DATA(ND), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pend(irq_pend),
        .dev_start(dev_start), .dev_cmd(dev_cmd), .dev_data(dev_data),
        .dev_done(dev_done), .dev_err(dev_err)
    );

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read values and compares with the bus
    always @(rd_ev) begin
        #1;
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic rd_exp(input int a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        bus_addr = AW'(a);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        ->rd_ev;
        #2;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic finish_op(input logic [3:0] e);
        @(negedge clk);
        dev_done = 1'b1; dev_err = e;
        @(negedge clk);
        dev_done = 1'b0; dev_err = 4'h0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_exp(1, 16'h0000, "R1 status");
        rd_exp(2, 16'h0000, "R1 data0");
        chk(DW'(irq_pend), 0, "R1 irq");
        // R6 data writes while idle
        wr(2, 16'hA5A5);
        wr(3, 16'h1234);
        rd_exp(2, 16'hA5A5, "R6 data0 idle");
        rd_exp(3, 16'h1234, "R6 data1 idle");
        // R3 accept
        wr(0, 16'h0042);
        chk(DW'(dev_start), 1, "R3 start pulse");
        chk(dev_cmd, 16'h0042, "R3 dev_cmd");
        rd_exp(1, 16'h0002, "R2 R3 status busy");
        chk(DW'(dev_start), 0, "R3 start single");
        rd_exp(0, 16'h0042, "R2 cmd readback");
        // R6 data write while busy is ignored
        wr(2, 16'hFFFF);
        rd_exp(2, 16'hA5A5, "R6 data0 busy");
        chk(dev_data[DW-1:0], 16'hA5A5, "R6 dev_data");
        // R5 refused command while busy
        wr(0, 16'h0099);
        chk(DW'(dev_start), 0, "R5 no start busy");
        rd_exp(1, 16'h00F2, "R5 refused busy");
        chk(dev_cmd, 16'h0042, "R5 cmd kept");
        // R4 completion, refusal code sticks
        finish_op(4'h3);
        rd_exp(1, 16'h00F1, "R4 R5 done sticky");
        chk(DW'(irq_pend), 1, "R4 irq");
        // R7 ack with bit0=1 does nothing, bit0=0 clears
        wr(1, 16'h0001);
        rd_exp(1, 16'h00F1, "R7 no clear");
        wr(1, 16'h0000);
        rd_exp(1, 16'h00F0, "R7 cleared");
        chk(DW'(irq_pend), 0, "R7 irq cleared");
        // R9 completion while idle ignored
        finish_op(4'h6);
        rd_exp(1, 16'h00F0, "R9 idle ignore");
        chk(DW'(irq_pend), 0, "R9 irq");
        // second operation with device code
        wr(0, 16'h0007);
        rd_exp(1, 16'h0002, "R5 code cleared on accept");
        finish_op(4'h5);
        rd_exp(1, 16'h0051, "R4 dev code");
        chk(DW'(irq_pend), 1, "R4 irq second");
        wr(0, 16'h0011);
        chk(DW'(dev_start), 0, "R5 no start done");
        rd_exp(1, 16'h00F1, "R5 refused done");
        wr(3, 16'hBEEF);
        rd_exp(3, 16'hBEEF, "R6 data1 done");
        wr(1, 16'h0000);
        rd_exp(1, 16'h00F0, "R7 cleared again");
        // R8 ack coinciding with completion
        wr(0, 16'h0009);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(1); bus_wdata = 16'h0000;
        dev_done = 1'b1; dev_err = 4'h2;
        @(negedge clk);
        bus_wr = 1'b0; dev_done = 1'b0; dev_err = 4'h0;
        rd_exp(1, 16'h0021, "R8 done kept");
        chk(DW'(irq_pend), 1, "R8 irq kept");
        chk(DW'(bus_rdata[1:0] == 2'b11), 0, "R10 flags");
        wr(1, 16'h0000);
        rd_exp(1, 16'h0020, "R7 final clear");
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule